// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block runs beside a simple 32-bit core and takes control whenever a synchronous fault, a trap or an external interrupt request must divert execution. It picks the winning event and its vector number, and it decides which return address to keep: the faulting instruction's own address for a fault, or the already advanced pointer for a trap or an interrupt. It then finds the handler's gate descriptor in a table in memory, using a 48-bit table register that holds a byte limit and a base address.

Once the descriptor passes the limit check, the block reads it as two 32-bit words. It writes the flags, the code selector and the return address below the current stack pointer, and adds a 32-bit error code for the few exception vectors that carry one. It then pulses `done` with the handler's selector, its rebuilt 32-bit entry offset, the lowered stack pointer and the flags with the trap bit cleared. A descriptor that lies past the limit ends the sequence with a one-cycle `limit_err` pulse and no memory traffic.

Top module: `exc_entry_seq`

## Requirements
- R1: A fault (`fault_req` high in the idle state) is entered with vector `fault_vec`, and `fault_ip`, the faulting instruction's own address, is saved as the return address.
- R2: A trap fires when `retire_valid` is high and either `trap_req` is high or bit 8 (trap flag) of `flags_in` is set. Its vector is `trap_vec` when `trap_req` is high and 1 (single step) otherwise, and `retire_next_ip` is saved as the return address.
- R3: A fault beats a trap, which beats an interrupt. `irq_req` is taken only while bit 9 (interrupt enable) of `flags_in` is set, and it then saves `retire_next_ip`. When the enable bit is clear, the block stays idle.
- R4: An accepted interrupt raises `irq_ack` for exactly one cycle, in the cycle after the request was sampled. `irq_ack` stays low for faults and traps.
- R5: `tbl_reg[15:0]` is the table limit and `tbl_reg[47:16]` the base. The descriptor is read as two words at base+vector×8 and then base+vector×8+4. Each read holds `rd_valid` and `rd_addr` until `rd_ready`.
- R6: If vector×8+7 is greater than the limit, `limit_err` pulses for one cycle and no read or write is issued. A vector whose last byte equals the limit is accepted.
- R7: The pushes write, in order, the flags at sp−4, the selector zero-extended at sp−8 and the return address at sp−12. Here sp is `sp_in` at acceptance. Each write holds `wr_valid`, `wr_addr` and `wr_data` until `wr_ready`.
- R8: For vectors 8, 10, 11, 12, 13 and 14 only, `err_code_in` is written as a fourth push at sp−16.
- R9: `done` pulses for one cycle at the end. `new_cs` is descriptor bits 31:16, and `new_ip` is descriptor bits 63:48 above bits 15:0. `new_sp` is sp less 4 per push.
- R10: With `done`, `new_flags` equals the latched `flags_in` with bit 8 cleared.
- R11: After reset the block is idle with all strobes low. Read and write strobes are never high together, and `done` and `limit_err` never coincide with each other or with a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_req | input | 1 | Fault event this cycle |
| fault_vec | input | 8 | Fault vector number |
| fault_ip | input | 32 | Address of the faulting instruction |
| retire_valid | input | 1 | An instruction completed this cycle |
| retire_next_ip | input | 32 | Advanced pointer (next instruction) |
| trap_req | input | 1 | Explicit trap on the retiring instruction |
| trap_vec | input | 8 | Explicit trap vector |
| irq_req | input | 1 | External interrupt request (level) |
| irq_vec | input | 8 | Interrupt vector |
| irq_ack | output | 1 | Interrupt vector latched |
| flags_in | input | 32 | Core flags register |
| cs_in | input | 16 | Current code selector |
| sp_in | input | 32 | Current stack pointer |
| err_code_in | input | 32 | Error code for vectors that push one |
| tbl_reg | input | 48 | Descriptor table base and limit |
| rd_valid | output | 1 | Descriptor read request |
| rd_addr | output | 32 | Descriptor read address |
| rd_ready | input | 1 | Read accepted, `rd_data` valid |
| rd_data | input | 32 | Read data |
| wr_valid | output | 1 | Stack write request |
| wr_addr | output | 32 | Stack write address |
| wr_data | output | 32 | Stack write data |
| wr_ready | input | 1 | Write accepted |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Entry complete, outputs below valid |
| limit_err | output | 1 | Descriptor outside table limit |
| new_cs | output | 16 | Handler code selector |
| new_ip | output | 32 | Handler entry offset |
| new_flags | output | 32 | Flags with trap bit cleared |
| new_sp | output | 32 | Stack pointer after pushes |

## Verification
On every cycle the assertions check the protocol properties: the acknowledge is a single-cycle pulse, read and write requests stay stable under back-pressure, strobes and completion pulses are mutually exclusive, and the trap flag is clear in the flags handed back. The bench scenarios show the behaviour that depends on values. These are the choice of return address per event class, the order among simultaneous events, the masking of interrupts, the exact descriptor addresses, the limit boundary at vector 31 against vector 32, the push order and which vectors add an error code, and the rebuilt entry point.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_RDLO,
    S_RDHI,
    S_PUSH,
    S_FIN,
    S_LERR
  } seq_state_e;

  // vectors whose entry adds an error-code word to the stack frame
  localparam int ERR_VEC_LIST_N = 6;
  localparam int ERR_VEC_LIST [ERR_VEC_LIST_N] = '{8, 10, 11, 12, 13, 14};

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int VEC_W    = 8,
  parameter int ADDR_W   = 32,
  parameter int STEP_VEC = 1
) (
  input  logic              fault_req,
  input  logic [VEC_W-1:0]  fault_vec,
  input  logic [ADDR_W-1:0] fault_ip,
  input  logic              retire_valid,
  input  logic [ADDR_W-1:0] retire_next_ip,
  input  logic              trap_req,
  input  logic [VEC_W-1:0]  trap_vec,
  input  logic              irq_req,
  input  logic [VEC_W-1:0]  irq_vec,
  input  logic              tf_flag,
  input  logic              ie_flag,
  output logic              take,
  output logic              take_irq,
  output logic [VEC_W-1:0]  vec,
  output logic [ADDR_W-1:0] ret_ip
);

  logic trap_hit;
  logic irq_hit;

  assign trap_hit = retire_valid & (trap_req | tf_flag);
  assign irq_hit  = irq_req & ie_flag;

  always_comb begin
    take     = 1'b0;
    take_irq = 1'b0;
    vec      = '0;
    ret_ip   = retire_next_ip;
    if (fault_req) begin
      take   = 1'b1;
      vec    = fault_vec;
      ret_ip = fault_ip;
    end else if (trap_hit) begin
      take = 1'b1;
      vec  = trap_req ? trap_vec : VEC_W'(STEP_VEC);
    end else if (irq_hit) begin
      take     = 1'b1;
      take_irq = 1'b1;
      vec      = irq_vec;
    end
  end

endmodule

// File: rtl/exc_gate_decode.sv
module exc_gate_decode import exc_pkg::*; #(
  parameter int VEC_W  = 8,
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16,
  parameter int LIM_W  = 16
) (
  input  logic [VEC_W-1:0]        vec,
  input  logic [LIM_W+ADDR_W-1:0] tbl_reg,
  input  logic [ADDR_W-1:0]       lo_word,
  input  logic [ADDR_W-1:0]       hi_word,
  output logic [ADDR_W-1:0]       desc_addr,
  output logic                    limit_bad,
  output logic                    needs_err,
  output logic [SEL_W-1:0]        sel,
  output logic [ADDR_W-1:0]       entry
);

  localparam int HALF_W = ADDR_W / 2;
  localparam int OFS_W  = VEC_W + 3;
  localparam int CMP_W  = (OFS_W > LIM_W) ? OFS_W : LIM_W;

  logic [ADDR_W-1:0] base;
  logic [LIM_W-1:0]  limit;
  logic [OFS_W-1:0]  first_byte;
  logic [OFS_W-1:0]  last_byte;

  assign limit      = tbl_reg[LIM_W-1:0];
  assign base       = tbl_reg[LIM_W+ADDR_W-1:LIM_W];
  assign first_byte = {vec, 3'b000};
  assign last_byte  = {vec, 3'b111};
  assign desc_addr  = base + ADDR_W'(first_byte);
  assign limit_bad  = CMP_W'(last_byte) > CMP_W'(limit);

  logic [ERR_VEC_LIST_N-1:0] err_hit;
  for (genvar g = 0; g < ERR_VEC_LIST_N; g++) begin : g_err
    assign err_hit[g] = (vec == VEC_W'(ERR_VEC_LIST[g]));
  end
  assign needs_err = |err_hit;

  assign sel   = lo_word[HALF_W +: SEL_W];
  assign entry = {hi_word[ADDR_W-1:HALF_W], lo_word[HALF_W-1:0]};

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq import exc_pkg::*; #(
  parameter int VEC_W    = 8,
  parameter int ADDR_W   = 32,
  parameter int SEL_W    = 16,
  parameter int LIM_W    = 16,
  parameter int TF_BIT   = 8,
  parameter int IF_BIT   = 9,
  parameter int STEP_VEC = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fault_req,
  input  logic [VEC_W-1:0]        fault_vec,
  input  logic [ADDR_W-1:0]       fault_ip,
  input  logic                    retire_valid,
  input  logic [ADDR_W-1:0]       retire_next_ip,
  input  logic                    trap_req,
  input  logic [VEC_W-1:0]        trap_vec,
  input  logic                    irq_req,
  input  logic [VEC_W-1:0]        irq_vec,
  output logic                    irq_ack,
  input  logic [ADDR_W-1:0]       flags_in,
  input  logic [SEL_W-1:0]        cs_in,
  input  logic [ADDR_W-1:0]       sp_in,
  input  logic [ADDR_W-1:0]       err_code_in,
  input  logic [LIM_W+ADDR_W-1:0] tbl_reg,
  output logic                    rd_valid,
  output logic [ADDR_W-1:0]       rd_addr,
  input  logic                    rd_ready,
  input  logic [ADDR_W-1:0]       rd_data,
  output logic                    wr_valid,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [ADDR_W-1:0]       wr_data,
  input  logic                    wr_ready,
  output logic                    busy,
  output logic                    done,
  output logic                    limit_err,
  output logic [SEL_W-1:0]        new_cs,
  output logic [ADDR_W-1:0]       new_ip,
  output logic [ADDR_W-1:0]       new_flags,
  output logic [ADDR_W-1:0]       new_sp
);

  localparam int WORD_B = ADDR_W / 8;
  localparam int IDX_W  = 2;

  seq_state_e        state_q, state_d;
  logic              ack_q, ack_d;
  logic [VEC_W-1:0]  vec_q;
  logic [ADDR_W-1:0] ret_q, flags_q, err_q, lo_q, hi_q;
  logic [SEL_W-1:0]  cs_q;
  logic [ADDR_W-1:0] sp_q, sp_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              acc_en, lo_en, hi_en, sp_en, idx_en;

  logic              take, take_irq;
  logic [VEC_W-1:0]  arb_vec;
  logic [ADDR_W-1:0] arb_ret;
  logic [ADDR_W-1:0] desc_addr;
  logic              limit_bad, needs_err;
  logic [IDX_W-1:0]  last_idx;

  exc_arbiter #(
    .VEC_W(VEC_W), .ADDR_W(ADDR_W), .STEP_VEC(STEP_VEC)
  ) u_arb (
    .fault_req      (fault_req),
    .fault_vec      (fault_vec),
    .fault_ip       (fault_ip),
    .retire_valid   (retire_valid),
    .retire_next_ip (retire_next_ip),
    .trap_req       (trap_req),
    .trap_vec       (trap_vec),
    .irq_req        (irq_req),
    .irq_vec        (irq_vec),
    .tf_flag        (flags_in[TF_BIT]),
    .ie_flag        (flags_in[IF_BIT]),
    .take           (take),
    .take_irq       (take_irq),
    .vec            (arb_vec),
    .ret_ip         (arb_ret)
  );

  exc_gate_decode #(
    .VEC_W(VEC_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .LIM_W(LIM_W)
  ) u_dec (
    .vec       (vec_q),
    .tbl_reg   (tbl_reg),
    .lo_word   (lo_q),
    .hi_word   (hi_q),
    .desc_addr (desc_addr),
    .limit_bad (limit_bad),
    .needs_err (needs_err),
    .sel       (new_cs),
    .entry     (new_ip)
  );

  assign last_idx = needs_err ? IDX_W'(3) : IDX_W'(2);

  // next-state and enables
  always_comb begin
    state_d = state_q;
    ack_d   = 1'b0;
    acc_en  = 1'b0;
    lo_en   = 1'b0;
    hi_en   = 1'b0;
    sp_en   = 1'b0;
    sp_d    = sp_q;
    idx_en  = 1'b0;
    idx_d   = idx_q;
    case (state_q)
      S_IDLE: begin
        if (take) begin
          state_d = S_CHECK;
          acc_en  = 1'b1;
          ack_d   = take_irq;
          sp_en   = 1'b1;
          sp_d    = sp_in;
        end
      end
      S_CHECK: state_d = limit_bad ? S_LERR : S_RDLO;
      S_RDLO: begin
        if (rd_ready) begin
          lo_en   = 1'b1;
          state_d = S_RDHI;
        end
      end
      S_RDHI: begin
        if (rd_ready) begin
          hi_en   = 1'b1;
          idx_en  = 1'b1;
          idx_d   = '0;
          state_d = S_PUSH;
        end
      end
      S_PUSH: begin
        if (wr_ready) begin
          sp_en  = 1'b1;
          sp_d   = sp_q - ADDR_W'(WORD_B);
          idx_en = 1'b1;
          idx_d  = IDX_W'(idx_q + 1'b1);
          if (idx_q == last_idx) state_d = S_FIN;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ack_q   <= 1'b0;
      vec_q   <= '0;
      ret_q   <= '0;
      flags_q <= '0;
      cs_q    <= '0;
      err_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      sp_q    <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
      if (acc_en) begin
        vec_q   <= arb_vec;
        ret_q   <= arb_ret;
        flags_q <= flags_in;
        cs_q    <= cs_in;
        err_q   <= err_code_in;
      end
      if (lo_en)  lo_q  <= rd_data;
      if (hi_en)  hi_q  <= rd_data;
      if (sp_en)  sp_q  <= sp_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  // outputs
  always_comb begin
    case (idx_q)
      2'd0:    wr_data = flags_q;
      2'd1:    wr_data = ADDR_W'(cs_q);
      2'd2:    wr_data = ret_q;
      default: wr_data = err_q;
    endcase
  end

  assign irq_ack   = ack_q;
  assign rd_valid  = (state_q == S_RDLO) || (state_q == S_RDHI);
  assign rd_addr   = (state_q == S_RDHI) ? desc_addr + ADDR_W'(WORD_B) : desc_addr;
  assign wr_valid  = (state_q == S_PUSH);
  assign wr_addr   = sp_q - ADDR_W'(WORD_B);
  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_FIN);
  assign limit_err = (state_q == S_LERR);
  assign new_sp    = sp_q;

  always_comb begin
    new_flags         = flags_q;
    new_flags[TF_BIT] = 1'b0;
  end

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int TF_BIT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_ack,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] wr_data,
  input logic              done,
  input logic              limit_err,
  input logic [ADDR_W-1:0] new_flags
);

  assert_ack_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  assert_lerr_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    limit_err |=> !rd_valid && !wr_valid);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_tf_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !new_flags[TF_BIT]);

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, wr_valid, done, limit_err}));

endmodule

bind exc_entry_seq exc_entry_seq_chk #(.ADDR_W(ADDR_W), .TF_BIT(TF_BIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_ack   (irq_ack),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_addr   (rd_addr),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .done      (done),
  .limit_err (limit_err),
  .new_flags (new_flags)
);

// File: tb/tb_exc_entry_seq.sv
`timescale 1ns/1ps
module tb_exc_entry_seq;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        fault_req, retire_valid, trap_req, irq_req;
  logic [7:0]  fault_vec, trap_vec, irq_vec;
  logic [31:0] fault_ip, retire_next_ip, flags_in, sp_in, err_code_in;
  logic [15:0] cs_in;
  logic [47:0] tbl_reg;
  logic        irq_ack, rd_valid, rd_ready, wr_valid, wr_ready;
  logic [31:0] rd_addr, rd_data, wr_addr, wr_data;
  logic        busy, done, limit_err;
  logic [15:0] new_cs;
  logic [31:0] new_ip, new_flags, new_sp;

  exc_entry_seq dut (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // memory model
  logic stall_en = 1'b0;
  logic tog = 1'b0;
  int n_rd, n_wr;
  logic [31:0] rd_log [8];
  logic [31:0] wa_log [8];
  logic [31:0] wd_log [8];

  function automatic logic [31:0] dword(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0] + 16'h1234};
  endfunction

  always @(negedge clk) begin
    tog      = ~tog;
    rd_ready = rd_valid && (!stall_en || tog);
    rd_data  = dword(rd_addr);
    wr_ready = wr_valid && (!stall_en || tog);
  end

  always @(posedge clk) begin
    if (rd_valid && rd_ready) begin
      if (n_rd < 8) rd_log[n_rd] = rd_addr;
      n_rd++;
    end
    if (wr_valid && wr_ready) begin
      if (n_wr < 8) begin
        wa_log[n_wr] = wr_addr;
        wd_log[n_wr] = wr_data;
      end
      n_wr++;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // results of one event
  int acks;
  bit got_done, got_lerr, got_busy;
  logic [15:0] c_cs;
  logic [31:0] c_ip, c_flags, c_sp;

  task automatic fire(input bit f, input [7:0] fv, input bit rv, input bit tq,
                      input [7:0] tv, input bit iq, input [7:0] iv);
    @(negedge clk);
    n_rd = 0; n_wr = 0; acks = 0; got_done = 0; got_lerr = 0;
    fault_req = f; fault_vec = fv; retire_valid = rv; trap_req = tq;
    trap_vec = tv; irq_req = iq; irq_vec = iv;
    @(negedge clk);
    fault_req = 0; retire_valid = 0; trap_req = 0;
    if (irq_ack) acks++;
    irq_req = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (irq_ack) acks++;
      if (done || limit_err) begin
        got_done = done; got_lerr = limit_err;
        c_cs = new_cs; c_ip = new_ip; c_flags = new_flags; c_sp = new_sp;
        break;
      end
    end
    @(negedge clk);
  endtask

  task automatic verify(input string tag, input [7:0] vec, input [31:0] ret,
                        input [31:0] base, input int exp_acks);
    logic [31:0] a, lo, hi;
    bit ec;
    a  = base + {21'd0, vec, 3'b000};
    lo = dword(a);
    hi = dword(a + 4);
    ec = (vec == 8) || (vec >= 10 && vec <= 14);
    chk(tag, "done seen", 32'(got_done), 32'd1);
    chk(tag, "irq_ack pulses", 32'(acks), 32'(exp_acks));
    chk("R5", "read count", 32'(n_rd), 32'd2);
    chk("R5", "read lo addr", rd_log[0], a);
    chk("R5", "read hi addr", rd_log[1], a + 4);
    chk("R8", "write count", 32'(n_wr), ec ? 32'd4 : 32'd3);
    chk("R7", "flags addr", wa_log[0], sp_in - 4);
    chk("R7", "flags data", wd_log[0], flags_in);
    chk("R7", "cs addr", wa_log[1], sp_in - 8);
    chk("R7", "cs data", wd_log[1], {16'd0, cs_in});
    chk("R7", "ret addr", wa_log[2], sp_in - 12);
    chk(tag, "ret data", wd_log[2], ret);
    if (ec) begin
      chk("R8", "err addr", wa_log[3], sp_in - 16);
      chk("R8", "err data", wd_log[3], err_code_in);
    end
    chk("R9", "new_cs", {16'd0, c_cs}, {16'd0, lo[31:16]});
    chk("R9", "new_ip", c_ip, {hi[31:16], lo[15:0]});
    chk("R9", "new_sp", c_sp, sp_in - (ec ? 32'd16 : 32'd12));
    chk("R10", "new_flags", c_flags, flags_in & ~32'h100);
  endtask

  task automatic t_reset;
    chk("R11", "busy after reset", 32'(busy), 0);
    chk("R11", "done after reset", 32'(done), 0);
    chk("R11", "rd_valid after reset", 32'(rd_valid), 0);
    chk("R11", "wr_valid after reset", 32'(wr_valid), 0);
    chk("R4", "irq_ack after reset", 32'(irq_ack), 0);
    chk("R6", "limit_err after reset", 32'(limit_err), 0);
  endtask

  task automatic t_fault_errcode;
    flags_in = 32'h0000_0202; sp_in = 32'h0000_8000; err_code_in = 32'hDEAD_0013;
    fire(1, 8'd13, 0, 0, 0, 0, 0);
    verify("R1", 8'd13, fault_ip, 32'h0010_0000, 0);
  endtask

  task automatic t_single_step;
    flags_in = 32'h0000_0302; sp_in = 32'h0000_7F00;
    fire(0, 0, 1, 0, 0, 0, 0);
    verify("R2", 8'd1, retire_next_ip, 32'h0010_0000, 0);
  endtask

  task automatic t_sw_trap_stall;
    stall_en = 1'b1;
    flags_in = 32'h0000_0002; sp_in = 32'h0000_6004;
    fire(0, 0, 1, 1, 8'd3, 0, 0);
    verify("R2", 8'd3, retire_next_ip, 32'h0010_0000, 0);
    stall_en = 1'b0;
  endtask

  task automatic t_irq;
    flags_in = 32'h0000_0202; sp_in = 32'h0000_5000;
    fire(0, 0, 0, 0, 0, 1, 8'h40);
    verify("R4", 8'h40, retire_next_ip, 32'h0010_0000, 1);
  endtask

  task automatic t_irq_masked;
    flags_in = 32'h0000_0002;
    got_busy = 0; acks = 0;
    @(negedge clk);
    irq_req = 1; irq_vec = 8'h41;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (busy) got_busy = 1;
      if (irq_ack) acks++;
    end
    irq_req = 0;
    chk("R3", "busy with interrupts masked", 32'(got_busy), 0);
    chk("R3", "ack with interrupts masked", 32'(acks), 0);
  endtask

  task automatic t_priority;
    flags_in = 32'h0000_0302; sp_in = 32'h0000_4000; err_code_in = 32'h0000_0E0E;
    fire(1, 8'd14, 1, 1, 8'd3, 1, 8'h50);
    verify("R3", 8'd14, fault_ip, 32'h0010_0000, 0);
    flags_in = 32'h0000_0202;
    fire(0, 0, 1, 1, 8'd4, 1, 8'h50);
    verify("R3", 8'd4, retire_next_ip, 32'h0010_0000, 0);
  endtask

  task automatic t_limit;
    tbl_reg = {32'h0020_0000, 16'h00FF};
    flags_in = 32'h0000_0002; sp_in = 32'h0000_3000;
    fire(1, 8'd31, 0, 0, 0, 0, 0);
    verify("R6", 8'd31, fault_ip, 32'h0020_0000, 0);
    fire(1, 8'd32, 0, 0, 0, 0, 0);
    chk("R6", "limit_err seen", 32'(got_lerr), 1);
    chk("R6", "done on limit error", 32'(got_done), 0);
    chk("R6", "reads on limit error", 32'(n_rd), 0);
    chk("R6", "writes on limit error", 32'(n_wr), 0);
    tbl_reg = {32'h0010_0000, 16'h07FF};
  endtask

  task automatic t_errcode_set;
    flags_in = 32'h0000_0002; sp_in = 32'h0000_2000; err_code_in = 32'h0000_0808;
    fire(1, 8'd8, 0, 0, 0, 0, 0);
    verify("R8", 8'd8, fault_ip, 32'h0010_0000, 0);
    fire(1, 8'd9, 0, 0, 0, 0, 0);
    verify("R8", 8'd9, fault_ip, 32'h0010_0000, 0);
    fire(1, 8'd15, 0, 0, 0, 0, 0);
    verify("R8", 8'd15, fault_ip, 32'h0010_0000, 0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 0;
    fault_req = 0; retire_valid = 0; trap_req = 0; irq_req = 0;
    fault_vec = 0; trap_vec = 0; irq_vec = 0;
    fault_ip = 32'h0000_1000; retire_next_ip = 32'h0000_1004;
    flags_in = 32'h2; cs_in = 16'h0008; sp_in = 32'h8000; err_code_in = 0;
    tbl_reg = {32'h0010_0000, 16'h07FF};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fault_errcode();
    cs_in = 16'h0023; fault_ip = 32'h0000_2220; retire_next_ip = 32'h0000_2226;
    t_single_step();
    t_sw_trap_stall();
    t_irq();
    t_irq_masked();
    t_priority();
    t_limit();
    t_errcode_set();
    summary();
  end

endmodule